// File: doc/BRIEF.md
# Link Power Status Monitor

This block supervises the power-status signal that the link controller presents to the physical layer. That signal may be a steady high level or a pulse train, so the block measures how long it stays low without a break. A short dropout, one that is longer than the short threshold but ends before the long threshold, produces a timed reset pulse on the PHY-link interface, after which the interface is enabled again. A dropout that reaches the long threshold disables the interface. Repeating on the cable is handled elsewhere and continues while the interface is disabled.

While the interface is disabled, a link-on indication from the packet receiver starts a link-on clock, which is the system clock divided by eight. The clock is driven on a pin that has a second use. During hardware reset the same pin is an input, and the level seen on it sets the default contender bit. The link-on clock stops, and the interface comes back, only when the link reports power and software has set the link-active bit. The block also provides the link bit for self-identification. All logic runs on the system clock.

Top module: `link_power_watch`

## Requirements
- R1: While `rst_n` is low, `pin_oe` is 0 and `contender_dflt` follows `pin_in`. From the first clock with `rst_n` high, `pin_oe` is 1 and `contender_dflt` holds the last level sampled during reset.
- R2: After reset the block is in the enabled state: `if_enable`=1, `if_reset`=0, `pin_out`=0.
- R3: A run of fewer than SHORT_THR (default 59) consecutive low samples of `lps_in` has no effect. A single high sample restarts the count.
- R4: A run of at least SHORT_THR and fewer than LONG_THR (default 1229) low samples, followed by a high sample, drops `if_enable` at the next clock. `if_reset` is then held high for RST_CYC (default 4) cycles, after which `if_enable` returns to 1.
- R5: LONG_THR consecutive low samples put the block in the disabled state (`if_enable`=0, `if_reset`=0) one clock later. Long-threshold expiry takes priority over the short-dropout reset.
- R6: In the disabled state, a `link_on_evt` pulse starts the link-on clock on `pin_out` with a period of 8 cycles: 4 cycles low, then 4 cycles high, beginning with the low half.
- R7: The link-on clock continues until a cycle in which `lps_in` and `link_active` are both 1. At the next clock `if_enable`=1 and `pin_out`=0.
- R8: `link_on_evt` has no effect unless the block is in the disabled state.
- R9: `self_id_link` is 1 exactly when `link_active` is 1 and the current run of low samples is shorter than SHORT_THR.
- R10: In the disabled state, a cycle with `lps_in`=1 and `link_active`=1 returns the block to the enabled state without a link-on clock. With `link_active`=0 the block stays disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| lps_in | input | 1 | Link power status, already synchronous to `clk` |
| link_on_evt | input | 1 | One-cycle pulse from the packet receiver on a link-on packet |
| link_active | input | 1 | Software link-active register bit |
| pin_in | input | 1 | Level read back from the shared strap/link-on pin |
| pin_out | output | 1 | Link-on clock driven onto the shared pin |
| pin_oe | output | 1 | Output enable for the shared pin |
| contender_dflt | output | 1 | Default contender bit taken from the strap |
| if_enable | output | 1 | PHY-link interface enable |
| if_reset | output | 1 | PHY-link interface reset pulse |
| self_id_link | output | 1 | Link bit for self-identification |

## Verification
The bench drives dropouts that end one sample before and exactly at each threshold. A design with an off-by-one counter would reset the interface on a 58-cycle dropout, or would treat a 1229-cycle dropout as a reset instead of a shutdown. Pulse trains with long low phases check that any high sample restarts the count. A counter that only pauses would accumulate the low time across pulses and reset the interface. Link-on events arrive while the block is enabled and while it is resetting, and `link_active` is held low while power returns. These cases catch a clock that starts in the wrong state, or one that stops on power alone. Two hardware resets with opposite strap levels check that the pin is read only while reset is asserted.

// File: rtl/lpw_pkg.sv
// Package lpw_pkg: shared types for the link power status monitor.
package lpw_pkg;

    // Interface control states
    typedef enum logic [1:0] {
        ST_ENABLED   = 2'd0,
        ST_RESETTING = 2'd1,
        ST_DISABLED  = 2'd2,
        ST_LINK_ON   = 2'd3
    } lpw_state_t;

endpackage

// File: rtl/lpw_idle_timer.sv
// Module lpw_idle_timer: counts consecutive low samples of the link power
// status and saturates at the long threshold.
// Assumes lps_in is synchronous to clk and SHORT_THR < LONG_THR.
module lpw_idle_timer #(
    parameter int SHORT_THR = 59,
    parameter int LONG_THR  = 1229
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_in,
    output logic short_seen,
    output logic long_hit,
    output logic lps_alive
);
    localparam int CNT_W = $clog2(LONG_THR + 1);

    logic [CNT_W-1:0] idle_cnt;

    // Restart on any high sample, otherwise count up to saturation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (lps_in) begin
            idle_cnt <= '0;
        end else if (idle_cnt != CNT_W'(LONG_THR)) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // Threshold decode
    always_comb begin
        short_seen = (idle_cnt >= CNT_W'(SHORT_THR));
        long_hit   = (idle_cnt == CNT_W'(LONG_THR));
        lps_alive  = !short_seen;
    end

endmodule

// File: rtl/lpw_ctrl_fsm.sv
// Module lpw_ctrl_fsm: decides between enabled, short reset, disabled and
// link-on. Assumes RST_CYC >= 1 and that the threshold flags come from
// lpw_idle_timer.
module lpw_ctrl_fsm
    import lpw_pkg::*;
#(
    parameter int RST_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lps_in,
    input  logic       link_active,
    input  logic       link_on_evt,
    input  logic       short_seen,
    input  logic       long_hit,
    output lpw_state_t state
);
    localparam int RC_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

    lpw_state_t      state_nx;
    logic [RC_W-1:0] rst_cnt;
    logic            wake_ok;

    // The link may return only if it is powered and software allows it
    always_comb wake_ok = lps_in && link_active;

    // Next-state selection
    always_comb begin
        state_nx = state;
        case (state)
            ST_ENABLED: begin
                if (long_hit)                  state_nx = ST_DISABLED;
                else if (lps_in && short_seen) state_nx = ST_RESETTING;
            end
            ST_RESETTING: begin
                if (long_hit)                               state_nx = ST_DISABLED;
                else if (rst_cnt == RC_W'(RST_CYC - 1))     state_nx = ST_ENABLED;
            end
            ST_DISABLED: begin
                if (wake_ok)          state_nx = ST_ENABLED;
                else if (link_on_evt) state_nx = ST_LINK_ON;
            end
            ST_LINK_ON: begin
                if (wake_ok) state_nx = ST_ENABLED;
            end
            default: state_nx = ST_ENABLED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ENABLED;
        else        state <= state_nx;
    end

    // Length of the interface reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_RESETTING) rst_cnt <= '0;
        else                                 rst_cnt <= rst_cnt + 1'b1;
    end

endmodule

// File: rtl/lpw_linkon_div.sv
// Module lpw_linkon_div: divides the system clock by 2**DIV_LOG2 while run
// is high and starts in the low half. Assumes DIV_LOG2 >= 1.
module lpw_linkon_div #(
    parameter int DIV_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic clk_out
);
    logic [DIV_LOG2-1:0] div_cnt;

    // Count while running and clear while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_cnt <= '0;
        else                div_cnt <= div_cnt + 1'b1;
    end

    // Output is the top bit, gated by run
    always_comb clk_out = run && div_cnt[DIV_LOG2-1];

endmodule

// File: rtl/lpw_strap.sv
// Module lpw_strap: samples the shared pin as a contender strap while reset
// is asserted and turns the pin into an output afterwards.
module lpw_strap (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic pin_oe,
    output logic contender
);
    // Capture the strap during reset and hold it afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) contender <= pin_in;
    end

    // The pin is released to the output driver after reset
    always_ff @(posedge clk) begin
        if (!rst_n) pin_oe <= 1'b0;
        else        pin_oe <= 1'b1;
    end

endmodule

// File: rtl/link_power_watch.sv
// Module link_power_watch: top level of the link power status monitor.
// It joins the idle timer, the control FSM, the link-on divider and the
// strap capture. Assumes all inputs are synchronous to clk.
module link_power_watch
    import lpw_pkg::*;
#(
    parameter int SHORT_THR = 59,
    parameter int LONG_THR  = 1229,
    parameter int RST_CYC   = 4,
    parameter int DIV_LOG2  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_in,
    input  logic link_on_evt,
    input  logic link_active,
    input  logic pin_in,
    output logic pin_out,
    output logic pin_oe,
    output logic contender_dflt,
    output logic if_enable,
    output logic if_reset,
    output logic self_id_link
);
    lpw_state_t state;
    logic       short_seen;
    logic       long_hit;
    logic       lps_alive;
    logic       div_clk;

    lpw_idle_timer #(.SHORT_THR(SHORT_THR), .LONG_THR(LONG_THR)) u_timer (
        .clk(clk), .rst_n(rst_n), .lps_in(lps_in),
        .short_seen(short_seen), .long_hit(long_hit), .lps_alive(lps_alive)
    );

    lpw_ctrl_fsm #(.RST_CYC(RST_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .lps_in(lps_in), .link_active(link_active),
        .link_on_evt(link_on_evt), .short_seen(short_seen),
        .long_hit(long_hit), .state(state)
    );

    lpw_linkon_div #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk(clk), .rst_n(rst_n), .run(state == ST_LINK_ON), .clk_out(div_clk)
    );

    lpw_strap u_strap (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .pin_oe(pin_oe), .contender(contender_dflt)
    );

    // Output decode
    always_comb begin
        if_enable    = (state == ST_ENABLED);
        if_reset     = (state == ST_RESETTING);
        pin_out      = div_clk;
        self_id_link = link_active && lps_alive;
    end

endmodule

// File: rtl/lpw_checker.sv
// Module lpw_checker: port-level properties of link_power_watch. It keeps
// its own count of low samples so that no long window is unrolled.
module lpw_checker #(
    parameter int SHORT_THR = 59,
    parameter int LONG_THR  = 1229,
    parameter int RST_CYC   = 4
) (
    input logic clk,
    input logic rst_n,
    input logic lps_in,
    input logic link_active,
    input logic pin_out,
    input logic pin_oe,
    input logic if_enable,
    input logic if_reset,
    input logic self_id_link
);
    int low_run;

    // Independent count of consecutive low samples
    always_ff @(posedge clk) begin
        if (!rst_n || lps_in)          low_run <= 0;
        else if (low_run <= LONG_THR)  low_run <= low_run + 1;
    end

    // R1: the pin is never driven in the cycle after reset was asserted
    a_r1_oe_low_in_reset: assert property (@(posedge clk)
        !rst_n |=> !pin_oe);

    // R2: the pin stays quiet while the interface is enabled
    a_r2_pin_quiet_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        if_enable |-> !pin_out);

    // R4: the reset pulse is longer than one cycle
    generate
        if (RST_CYC > 1) begin : g_pulse
            a_r4_reset_pulse_held: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(if_reset) |=> if_reset);
        end
    endgenerate

    // R5: a dropout past the long threshold leaves the interface off
    a_r5_off_after_long: assert property (@(posedge clk) disable iff (!rst_n)
        (low_run > LONG_THR) |-> (!if_enable && !if_reset));

    // R7: power plus link-active wakes a disabled interface at the next clock
    a_r7_wake_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!if_enable && !if_reset && lps_in && link_active) |=> (if_enable && !pin_out));

    // R9: the self-ID link bit drops once the dropout reaches the short threshold
    a_r9_self_id_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (low_run >= SHORT_THR) |-> !self_id_link);

endmodule

bind link_power_watch lpw_checker #(
    .SHORT_THR(SHORT_THR), .LONG_THR(LONG_THR), .RST_CYC(RST_CYC)
) u_lpw_checker (
    .clk(clk), .rst_n(rst_n), .lps_in(lps_in), .link_active(link_active),
    .pin_out(pin_out), .pin_oe(pin_oe), .if_enable(if_enable),
    .if_reset(if_reset), .self_id_link(self_id_link)
);

// File: tb/tb_link_power_watch.sv
// Bench tb_link_power_watch: a behavioural model is compared with the
// design on every clock, and each scenario is tagged with the requirement it targets.
module tb_link_power_watch;
    localparam int SHORT = 59;
    localparam int LONG  = 1229;
    localparam int RCYC  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lps_in = 1'b1;
    logic link_on_evt = 1'b0;
    logic link_active = 1'b1;
    logic pin_in = 1'b1;
    logic pin_out, pin_oe, contender_dflt, if_enable, if_reset, self_id_link;

    link_power_watch dut (
        .clk(clk), .rst_n(rst_n), .lps_in(lps_in), .link_on_evt(link_on_evt),
        .link_active(link_active), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .contender_dflt(contender_dflt), .if_enable(if_enable),
        .if_reset(if_reset), .self_id_link(self_id_link)
    );

    always #5 clk = ~clk;

    int    vectors = 0;
    int    errors  = 0;
    bit    started = 0;
    bit    done    = 0;
    string req_tag = "R1";

    // Model state: mode 0 enabled, 1 resetting, 2 disabled, 3 link-on
    int m_mode = 0, m_low = 0, m_rc = 0, m_lc = 0;
    bit m_oe = 0, m_cont = 0;

    // Behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_mode = 0; m_low = 0; m_rc = 0; m_lc = 0; m_oe = 0; m_cont = pin_in;
        end else begin
            m_oe = 1;
            if (m_mode == 0) begin
                if (m_low >= LONG) m_mode = 2;
                else if (lps_in && m_low >= SHORT) begin m_mode = 1; m_rc = 0; end
            end else if (m_mode == 1) begin
                if (m_low >= LONG) m_mode = 2;
                else if (m_rc == RCYC - 1) m_mode = 0;
                else m_rc++;
            end else if (m_mode == 2) begin
                if (lps_in && link_active) m_mode = 0;
                else if (link_on_evt) begin m_mode = 3; m_lc = 0; end
            end else begin
                if (lps_in && link_active) m_mode = 0;
                else m_lc++;
            end
            if (lps_in) m_low = 0;
            else if (m_low < LONG) m_low++;
        end
    end

    task automatic cmp(string name, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req_tag, name, act, exp, $time);
        end
    endtask

    // Compare after the inputs driven at this falling edge have settled
    always @(negedge clk) begin
        #2;
        if (started && !done) begin
            cmp("pin_oe", pin_oe, m_oe);
            cmp("contender_dflt", contender_dflt, m_cont);
            cmp("if_enable", if_enable, m_mode == 0);
            cmp("if_reset", if_reset, m_mode == 1);
            cmp("pin_out", pin_out, m_mode == 3 && (m_lc % 8) >= 4);
            cmp("self_id_link", self_id_link, link_active && m_low < SHORT);
        end
    end

    task automatic hold(logic lv, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lps_in = lv;
        end
    endtask

    task automatic pulse_evt();
        @(negedge clk); link_on_evt = 1'b1;
        @(negedge clk); link_on_evt = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(150000 * 10);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R1: strap high during reset, then release
        req_tag = "R1";
        hold(1'b1, 3);
        @(negedge clk); rst_n = 1'b1;
        // R2: steady power keeps the interface enabled
        req_tag = "R2";
        hold(1'b1, 10);
        // R3: pulse train with long lows, then a dropout one short of the threshold
        req_tag = "R3";
        for (int k = 0; k < 20; k++) begin hold(1'b0, 30); hold(1'b1, 1); end
        hold(1'b0, SHORT - 1); hold(1'b1, 8);
        // R4: dropouts exactly at the short threshold and mid-window
        req_tag = "R4";
        hold(1'b0, SHORT); hold(1'b1, 12);
        hold(1'b0, 600); hold(1'b1, 12);
        // R9: link-active bit and dropout both clear the self-ID link bit
        req_tag = "R9";
        @(negedge clk); link_active = 1'b0;
        hold(1'b1, 5);
        @(negedge clk); link_active = 1'b1;
        hold(1'b0, 70); hold(1'b1, 12);
        // R8: link-on events in the enabled and resetting states are ignored
        req_tag = "R8";
        pulse_evt(); hold(1'b1, 5);
        hold(1'b0, SHORT); hold(1'b1, 1); pulse_evt(); hold(1'b1, 10);
        // R5: dropout exactly at the long threshold disables the interface
        req_tag = "R5";
        @(negedge clk); link_active = 1'b0;
        hold(1'b0, LONG); hold(1'b1, 20); hold(1'b0, 10);
        // R6: a link-on event while disabled starts the divided clock
        req_tag = "R6";
        pulse_evt(); hold(1'b0, 40);
        // R7: power alone does not stop it; power and link-active together do
        req_tag = "R7";
        hold(1'b1, 20);
        @(negedge clk); link_active = 1'b1; lps_in = 1'b0;
        hold(1'b0, 10); hold(1'b1, 10);
        // R10: disabled, then woken without a link-on event
        req_tag = "R10";
        hold(1'b0, LONG + 70); hold(1'b1, 12);
        // R4: dropout one short of the long threshold is only a reset
        req_tag = "R4";
        hold(1'b0, LONG - 1); hold(1'b1, 12);
        // R1: second reset with the strap low
        req_tag = "R1";
        @(negedge clk); rst_n = 1'b0; pin_in = 1'b0;
        hold(1'b1, 3);
        @(negedge clk); rst_n = 1'b1; pin_in = 1'b1;
        hold(1'b1, 10);
        finish_run();
    end

endmodule